// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, once per clock, which hardware thread may use the instruction fetch path. Each thread reports a status code, an active flag and two occupancy counts: the issue queue and the load/store queue. A two-bit policy input chooses how the winner is picked. The choices are a single-thread mode, a round-robin mode driven by an ordered priority list, and two modes that favour the thread with the lowest occupancy in the chosen queue.

The round-robin list is internal state. It starts with every thread in ascending ID order. A granted thread moves to the tail. Separate activate and deactivate pulses add threads to the list and remove them from it. The grant is registered: the ID and valid flag seen after a rising edge come from the inputs sampled at that edge.

Top module: `thread_fetch_selector`

## Requirements
- R1: After reset the output valid flag is 0 and the round-robin list holds every thread in ascending ID order, so with all threads eligible round-robin grants 0, 1, 2, 3, 0 in turn.
- R2: A thread is eligible only when its 3-bit status code (bits 3t+2..3t of status_i) is 0 (running), 1 (memory access complete) or 2 (idle). Codes 3 to 7 make it ineligible in every policy.
- R3: Policy 1 (round-robin) walks the list from the head and grants the first eligible thread. That thread then moves to the tail, and the others keep their relative order.
- R4: A deactivate pulse removes the thread from the list, and round-robin never grants it again until it is reactivated. A grant in the same cycle is taken from the list as it stood before the pulse. Deactivate wins over a simultaneous activate.
- R5: An activate pulse appends an absent thread at the tail of the list, after any round-robin move of that cycle. Activating a thread that is already listed has no effect.
- R6: Policy 2 grants the active, eligible thread with the smallest issue-queue count (bits 6t+5..6t of iq_cnt_i). Ties go to the lower thread ID.
- R7: Policy 3 grants the active, eligible thread with the smallest load/store-queue count (lsq_cnt_i, same layout as R6). Ties go to the lower thread ID.
- R8: When no thread qualifies under the current policy, the valid flag is 0 and the round-robin list is left unchanged.
- R9: Policy 0 (single-thread) looks only at the lowest-numbered active thread and grants it when it is eligible. The grant is invalid when no thread or more than one thread is active. Grants under policies 0, 2 and 3 do not reorder the list.
- R10: The grant outputs change only at a rising clock edge and reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | 0 single, 1 round-robin, 2 min issue queue, 3 min load/store queue |
| status_i | input | 3*NT | Per-thread status code |
| active_i | input | NT | Per-thread active flag |
| iq_cnt_i | input | CW*NT | Per-thread issue-queue occupancy |
| lsq_cnt_i | input | CW*NT | Per-thread load/store-queue occupancy |
| activate_i | input | NT | One-cycle pulse that adds a thread to the list |
| deactivate_i | input | NT | One-cycle pulse that removes a thread from the list |
| grant_valid_o | output | 1 | A thread was selected |
| grant_id_o | output | TW | Selected thread ID |

## Verification
Every grant, and every list update it causes, is due on the first rising edge after the inputs are applied. The bench drives new inputs 1 ns after an edge and reads the outputs 1 ns after the next edge, so each result is sampled exactly one register stage later. For R10, one check changes the inputs in mid-cycle and confirms that the output still shows the previous grant before the edge. List effects (R3, R4, R5, R8) are checked through the sequence of round-robin grants that follows each pulse.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

    typedef enum logic [1:0] {
        POL_SINGLE  = 2'd0,
        POL_RR      = 2'd1,
        POL_MIN_IQ  = 2'd2,
        POL_MIN_LSQ = 2'd3
    } fsel_policy_e;

    localparam int ST_W = 3;
    localparam logic [ST_W-1:0] ST_RUN     = 3'd0;
    localparam logic [ST_W-1:0] ST_MEMDONE = 3'd1;
    localparam logic [ST_W-1:0] ST_IDLE    = 3'd2;

endpackage

// File: rtl/fsel_elig.sv
module fsel_elig
    import fsel_pkg::*;
#(
    parameter int NT = 4
) (
    input  logic [NT*ST_W-1:0] status_i,
    output logic [NT-1:0]      elig_o
);

    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic [ST_W-1:0] code;
        assign code      = status_i[t*ST_W +: ST_W];
        assign elig_o[t] = (code == ST_RUN) || (code == ST_MEMDONE) || (code == ST_IDLE);
    end

endmodule

// File: rtl/fsel_min_pick.sv
module fsel_min_pick #(
    parameter int NT = 4,
    parameter int CW = 6,
    localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic [NT-1:0]    cand_i,
    input  logic [NT*CW-1:0] cnt_i,
    output logic             found_o,
    output logic [TW-1:0]    id_o
);

    logic [CW-1:0] best_cnt;

    always_comb begin
        found_o  = 1'b0;
        id_o     = '0;
        best_cnt = '0;
        for (int t = 0; t < NT; t++) begin
            // strict compare keeps the lower ID on a tie
            if (cand_i[t] && (!found_o || (cnt_i[t*CW +: CW] < best_cnt))) begin
                found_o  = 1'b1;
                id_o     = TW'(t);
                best_cnt = cnt_i[t*CW +: CW];
            end
        end
    end

endmodule

// File: rtl/fsel_single_pick.sv
module fsel_single_pick #(
    parameter int NT = 4,
    localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic [NT-1:0] active_i,
    input  logic [NT-1:0] elig_i,
    output logic          found_o,
    output logic [TW-1:0] id_o
);

    logic first_seen;
    logic multi;

    always_comb begin
        first_seen = 1'b0;
        multi      = 1'b0;
        id_o       = '0;
        for (int t = 0; t < NT; t++) begin
            if (active_i[t]) begin
                if (first_seen) begin
                    multi = 1'b1;
                end else begin
                    first_seen = 1'b1;
                    id_o       = TW'(t);
                end
            end
        end
        found_o = first_seen && !multi && elig_i[id_o];
    end

endmodule

// File: rtl/thread_fetch_selector.sv
module thread_fetch_selector
    import fsel_pkg::*;
#(
    parameter int NT = 4,
    parameter int CW = 6,
    localparam int TW = (NT > 1) ? $clog2(NT) : 1,
    localparam int LW = $clog2(NT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         policy_i,
    input  logic [NT*ST_W-1:0] status_i,
    input  logic [NT-1:0]      active_i,
    input  logic [NT*CW-1:0]   iq_cnt_i,
    input  logic [NT*CW-1:0]   lsq_cnt_i,
    input  logic [NT-1:0]      activate_i,
    input  logic [NT-1:0]      deactivate_i,
    output logic               grant_valid_o,
    output logic [TW-1:0]      grant_id_o
);

    typedef struct packed {
        logic [NT-1:0][TW-1:0] list;
        logic [LW-1:0]         len;
        logic                  gv;
        logic [TW-1:0]         gid;
    } sel_state_t;

    sel_state_t s_d, s_q;

    logic [NT-1:0]    elig;
    logic [NT*CW-1:0] occ_sel;
    logic             occ_found, one_found;
    logic [TW-1:0]    occ_id, one_id;

    fsel_elig #(.NT(NT)) u_elig (
        .status_i (status_i),
        .elig_o   (elig)
    );

    assign occ_sel = (policy_i == POL_MIN_LSQ) ? lsq_cnt_i : iq_cnt_i;

    fsel_min_pick #(.NT(NT), .CW(CW)) u_min (
        .cand_i  (elig & active_i),
        .cnt_i   (occ_sel),
        .found_o (occ_found),
        .id_o    (occ_id)
    );

    fsel_single_pick #(.NT(NT)) u_one (
        .active_i (active_i),
        .elig_i   (elig),
        .found_o  (one_found),
        .id_o     (one_id)
    );

    logic                  rr_found;
    logic [TW-1:0]         rr_pos;
    logic [NT-1:0][TW-1:0] rot_list, flt_list;
    int                    rot_len, flt_len;
    logic                  present;

    always_comb begin
        s_d = s_q;

        // round-robin: first eligible entry from the head
        rr_found = 1'b0;
        rr_pos   = '0;
        for (int p = 0; p < NT; p++) begin
            if (!rr_found && (p < int'(s_q.len)) && elig[s_q.list[p]]) begin
                rr_found = 1'b1;
                rr_pos   = TW'(p);
            end
        end

        unique case (fsel_policy_e'(policy_i))
            POL_SINGLE: begin s_d.gv = one_found; if (one_found) s_d.gid = one_id; end
            POL_RR:     begin s_d.gv = rr_found;  if (rr_found)  s_d.gid = s_q.list[rr_pos]; end
            default:    begin s_d.gv = occ_found; if (occ_found) s_d.gid = occ_id; end
        endcase

        // step 1: move the round-robin winner to the tail
        rot_list = '0;
        rot_len  = 0;
        for (int p = 0; p < NT; p++) begin
            if ((p < int'(s_q.len)) &&
                !((policy_i == POL_RR) && rr_found && (TW'(p) == rr_pos))) begin
                rot_list[rot_len] = s_q.list[p];
                rot_len++;
            end
        end
        if ((policy_i == POL_RR) && rr_found) begin
            rot_list[rot_len] = s_q.list[rr_pos];
            rot_len++;
        end

        // step 2: drop deactivated threads
        flt_list = '0;
        flt_len  = 0;
        for (int p = 0; p < NT; p++) begin
            if ((p < rot_len) && !deactivate_i[rot_list[p]]) begin
                flt_list[flt_len] = rot_list[p];
                flt_len++;
            end
        end

        // step 3: append newly activated threads that are absent
        for (int t = 0; t < NT; t++) begin
            present = 1'b0;
            for (int p = 0; p < NT; p++) begin
                if ((p < flt_len) && (flt_list[p] == TW'(t))) present = 1'b1;
            end
            if (activate_i[t] && !deactivate_i[t] && !present && (flt_len < NT)) begin
                flt_list[flt_len] = TW'(t);
                flt_len++;
            end
        end

        s_d.list = flt_list;
        s_d.len  = LW'(flt_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NT; p++) s_q.list[p] <= TW'(p);
            s_q.len <= LW'(NT);
            s_q.gv  <= 1'b0;
            s_q.gid <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign grant_valid_o = s_q.gv;
    assign grant_id_o    = s_q.gid;

endmodule

// File: rtl/fsel_checker.sv
module fsel_checker
    import fsel_pkg::*;
#(
    parameter int NT = 4,
    parameter int CW = 6,
    localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         policy_i,
    input logic [NT*ST_W-1:0] status_i,
    input logic [NT-1:0]      active_i,
    input logic [NT*CW-1:0]   iq_cnt_i,
    input logic [NT*CW-1:0]   lsq_cnt_i,
    input logic               grant_valid_o,
    input logic [TW-1:0]      grant_id_o
);

    logic               p_ok;
    logic [1:0]         p_pol;
    logic [NT*ST_W-1:0] p_st;
    logic [NT-1:0]      p_act;
    logic [NT*CW-1:0]   p_iq, p_lsq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_ok <= 1'b0; p_pol <= '0; p_st <= '0; p_act <= '0; p_iq <= '0; p_lsq <= '0;
        end else begin
            p_ok <= 1'b1; p_pol <= policy_i; p_st <= status_i; p_act <= active_i;
            p_iq <= iq_cnt_i; p_lsq <= lsq_cnt_i;
        end
    end

    logic [ST_W-1:0] g_code;
    logic            any_ok, iq_beaten, lsq_beaten;

    always_comb begin
        g_code     = p_st[ST_W*int'(grant_id_o) +: ST_W];
        any_ok     = 1'b0;
        iq_beaten  = 1'b0;
        lsq_beaten = 1'b0;
        for (int t = 0; t < NT; t++) begin
            if (p_st[ST_W*t +: ST_W] <= 3'd2) begin
                any_ok = 1'b1;
                if (p_act[t]) begin
                    if ((p_iq[CW*t +: CW] < p_iq[CW*int'(grant_id_o) +: CW]) ||
                        ((p_iq[CW*t +: CW] == p_iq[CW*int'(grant_id_o) +: CW]) && (t < int'(grant_id_o))))
                        iq_beaten = 1'b1;
                    if ((p_lsq[CW*t +: CW] < p_lsq[CW*int'(grant_id_o) +: CW]) ||
                        ((p_lsq[CW*t +: CW] == p_lsq[CW*int'(grant_id_o) +: CW]) && (t < int'(grant_id_o))))
                        lsq_beaten = 1'b1;
                end
            end
        end
    end

    a_r2_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && grant_valid_o) |-> (g_code <= 3'd2));

    a_r8_none_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && !any_ok) |-> !grant_valid_o);

    a_r6_iq_min: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && grant_valid_o && (p_pol == 2'd2)) |-> (!iq_beaten && p_act[grant_id_o]));

    a_r7_lsq_min: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && grant_valid_o && (p_pol == 2'd3)) |-> (!lsq_beaten && p_act[grant_id_o]));

    a_r9_single_only: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && grant_valid_o && (p_pol == 2'd0)) |-> (($countones(p_act) == 1) && p_act[grant_id_o]));

endmodule

bind thread_fetch_selector fsel_checker #(.NT(NT), .CW(CW)) u_fsel_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .policy_i      (policy_i),
    .status_i      (status_i),
    .active_i      (active_i),
    .iq_cnt_i      (iq_cnt_i),
    .lsq_cnt_i     (lsq_cnt_i),
    .grant_valid_o (grant_valid_o),
    .grant_id_o    (grant_id_o)
);

// File: tb/thread_fetch_selector_tb_top.sv
`timescale 1ns/1ps
module thread_fetch_selector_tb_top;

    localparam int NT = 4;
    localparam int CW = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      pol = 2'd1;
    logic [11:0]     st = '0;
    logic [3:0]      act = 4'hF;
    logic [23:0]     iq = '0;
    logic [23:0]     lsq = '0;
    logic [3:0]      acti = '0;
    logic [3:0]      deact = '0;
    logic            gv;
    logic [1:0]      gid;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    thread_fetch_selector #(.NT(NT), .CW(CW)) dut_i (
        .clk (clk), .rst_n (rst_n), .policy_i (pol), .status_i (st),
        .active_i (act), .iq_cnt_i (iq), .lsq_cnt_i (lsq),
        .activate_i (acti), .deactivate_i (deact),
        .grant_valid_o (gv), .grant_id_o (gid)
    );

    typedef struct packed {
        logic [1:0]  pol;
        logic [11:0] st;
        logic [3:0]  act;
        logic [23:0] iq;
        logic [23:0] lsq;
        logic        ev;
        logic [1:0]  eid;
        logic [7:0]  tag;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 12'h000, 4'hF, {6'd3, 6'd7, 6'd3, 6'd5}, 24'h0, 1'b1, 2'd1, 8'd6},  // R6 tie -> lower
        '{2'd2, 12'h020, 4'hF, {6'd3, 6'd7, 6'd3, 6'd5}, 24'h0, 1'b1, 2'd3, 8'd2},  // R2 t1 code 4
        '{2'd2, 12'h000, 4'h7, {6'd1, 6'd7, 6'd6, 6'd5}, 24'h0, 1'b1, 2'd0, 8'd6},  // R6 inactive skipped
        '{2'd3, 12'h000, 4'hF, 24'h0, {6'd2, 6'd9, 6'd4, 6'd8}, 1'b1, 2'd3, 8'd7},  // R7
        '{2'd3, 12'h287, 4'hF, 24'h0, {6'd2, 6'd9, 6'd4, 6'd8}, 1'b1, 2'd3, 8'd2},  // R2 codes 1/2 ok, 7 not
        '{2'd3, 12'h6DB, 4'hF, 24'h0, {6'd2, 6'd9, 6'd4, 6'd8}, 1'b0, 2'd3, 8'd8},  // R8 all code 3
        '{2'd0, 12'h000, 4'h4, 24'h0, 24'h0, 1'b1, 2'd2, 8'd9},                     // R9 one active
        '{2'd0, 12'h140, 4'h4, 24'h0, 24'h0, 1'b0, 2'd2, 8'd9},                     // R9 not eligible
        '{2'd0, 12'h000, 4'h6, 24'h0, 24'h0, 1'b0, 2'd2, 8'd9},                     // R9 two active
        '{2'd0, 12'h000, 4'h0, 24'h0, 24'h0, 1'b0, 2'd2, 8'd9},                     // R9 none active
        '{2'd2, 12'h000, 4'hF, {4{6'd9}}, 24'h0, 1'b1, 2'd0, 8'd6},                 // R6 all equal
        '{2'd3, 12'h000, 4'h0, 24'h0, 24'h0, 1'b0, 2'd0, 8'd8}                      // R8 none active
    };

    task automatic tick();
        @(posedge clk);
        #1;
        acti  = '0;
        deact = '0;
    endtask

    task automatic check(input string req, input logic ev, input logic [1:0] eid);
        total++;
        if ((gv !== ev) || (ev && (gid !== eid))) begin
            bad++;
            $display("FAIL %s: got valid=%0b id=%0d, expected valid=%0b id=%0d", req, gv, gid, ev, eid);
        end
    endtask

    task automatic rr(input logic [1:0] eid, input string req);
        pol = 2'd1;
        tick();
        check(req, 1'b1, eid);
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 1'b0, 2'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            pol = VECS[i].pol; st = VECS[i].st; act = VECS[i].act;
            iq = VECS[i].iq; lsq = VECS[i].lsq;
            tick();
            check($sformatf("R%0d vec%0d", VECS[i].tag, i), VECS[i].ev, VECS[i].eid);
        end

        st = 12'h000; act = 4'hF;
        // R1 R3: ascending start order, winner moves to tail; table left list untouched (R9)
        rr(0, "R1"); rr(1, "R3"); rr(2, "R3"); rr(3, "R3"); rr(0, "R3");
        st = 12'h020;                       // t1 code 4
        rr(2, "R3 skip"); rr(3, "R3 skip");
        st = 12'h000;
        rr(1, "R3 order");
        deact = 4'b0100;                    // R4 remove t2, grant from old list
        rr(0, "R4 same cycle");
        rr(3, "R4"); rr(1, "R4"); rr(0, "R4"); rr(3, "R4");
        acti = 4'b0100;                     // R5 append t2 after move
        rr(1, "R5");
        rr(0, "R5"); rr(3, "R5"); rr(1, "R5"); rr(2, "R5 tail");
        acti = 4'b0001;                     // R5 already listed
        rr(0, "R5 present");
        rr(3, "R5 present"); rr(1, "R5 present"); rr(2, "R5 present"); rr(0, "R5 present");
        st = 12'h6DB;                       // R8 none eligible
        tick();
        check("R8 rr none", 1'b0, 2'd0);
        st = 12'h000;
        rr(3, "R8 list kept");

        // R10: mid-cycle input change is not visible before the edge
        pol = 2'd2; iq = {6'd5, 6'd1, 6'd5, 6'd5};
        #1;
        check("R10 hold", 1'b1, 2'd3);
        tick();
        check("R10 update", 1'b1, 2'd2);

        // R1: reset restores ascending order
        rst_n = 1'b0;
        #1;
        check("R1 async reset", 1'b0, 2'd0);
        tick();
        rst_n = 1'b1;
        rr(0, "R1 after reset");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule